// File: doc/BRIEF.md
# Register-Synthesized Section Table

The block serves bus reads of a 4096-slot first-level translation table that has no backing memory. Every word of the table is built when it is read, from a small set of configuration registers. One slot, 0x800, is a permanent identity entry for the on-chip register space. Sixteen programmable mapping entries can each be placed at any slot. A mapping entry can stretch over a power-of-two run of neighbouring slots, and within that run it hands out consecutive 1 MB section bases.

A table walker reads word address `WIN_BASE + 4*k` to fetch slot k. The answer appears one clock later with a valid strobe, as a short-form section descriptor. A slot that no entry claims returns the all-zero fault word. Software programs the entries through a simple write port. Each entry takes two registers: a location word and a control word. The block does not check for overlapping or invalid programming. Overlaps are resolved by a fixed priority.

Top module: `hw_l1pt`

## Requirements
- R1: A read hits slot k when `rd_addr_i` equals `WIN_BASE + 4*k` for k in 0..4095. Any address outside that window, or with bits [1:0] not zero, returns 32'h0000_0000.
- R2: Slot 0x800 always returns a descriptor with base 0x800 and C=0. Its AP, domain and B fields come from the fixed entry's registers. This slot wins over every mapping entry.
- R3: After reset, mapping entry n has location n, base n, span 0 and is enabled, with AP, domain, C and B all 0. The fixed entry's AP, domain and B are 0. So slot n (n<16) reads `n<<20 | 2`, and slot 0x800 reads 32'h8000_0002.
- R4: An enabled entry with location L and span s claims slots L through L+2^s−1 (s is 0..7). It does not wrap past slot 4095.
- R5: Slot L+i inside an entry's run gets section base (BASE+i) mod 4096.
- R6: An entry whose disable bit is set claims no slot.
- R7: When several enabled entries claim the same slot, the lowest-numbered entry supplies the descriptor.
- R8: A slot that is claimed by no enabled entry and is not slot 0x800 returns 32'h0000_0000.
- R9: `rd_valid_o` is high exactly one cycle after a cycle with `rd_en_i` high, and the data comes with it. In any other cycle, `rd_valid_o` and `rd_data_o` are 0.
- R10: Descriptor layout: [31:20] base, [11:10] AP, [8:5] domain, [3] C, [2] B, [1:0]=2'b10. All other bits are 0.
- R11: Write port: `cfg_idx_i` 0..15 selects a mapping entry and 16 selects the fixed entry. `cfg_sel_i`=0 writes the location from `cfg_wdata_i[11:0]`. `cfg_sel_i`=1 writes the control word: [2:0] span, [3] disable, [4] B, [5] C, [7:6] AP, [11:8] domain, [23:12] base. A write is visible to the next read.
- R12: Writes to index 17..31 are ignored. A location write to the fixed entry is ignored. A control write to the fixed entry keeps only AP, domain and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 32 | Byte address of the read |
| rd_valid_o | output | 1 | Read data valid, one cycle after request |
| rd_data_o | output | 32 | Section descriptor or fault word |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 5 | Entry index (16 = fixed entry) |
| cfg_sel_i | input | 1 | 0 = location word, 1 = control word |
| cfg_wdata_i | input | 24 | Write data |

## Verification
The bench uses the default parameters: sixteen entries, a 12-bit slot index, a 3-bit span and the standard window base. This lets it reach the top slot 4095, the largest span of 128 slots with base wrap-around, and a run that straddles the fixed slot 0x800. With sixteen entries, it can also stack two entries on the same slot to test the priority rule. The directed cases walk the reset mapping, the window edges, span boundaries, the disable bit, the ignored writes and the fixed-entry attributes.

// File: rtl/hw_l1pt_pkg.sv
package hw_l1pt_pkg;
  localparam int unsigned BASE_W = 12;
  localparam int unsigned DOM_W  = 4;
  localparam int unsigned AP_W   = 2;
  localparam int unsigned SPN_W  = 3;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [DOM_W-1:0]  dom;
    logic [AP_W-1:0]   ap;
    logic              c;
    logic              b;
    logic              dis;
    logic [SPN_W-1:0]  span;
  } ent_cfg_t;

  localparam int unsigned CFG_W = $bits(ent_cfg_t);

  function automatic logic [31:0] mk_desc(logic [BASE_W-1:0] base, logic [AP_W-1:0] ap,
                                          logic [DOM_W-1:0] dom, logic c, logic b);
    return {base, 8'h00, ap, 1'b0, dom, 1'b0, c, b, 2'b10};
  endfunction
endpackage

// File: rtl/l1pt_regs.sv
module l1pt_regs
  import hw_l1pt_pkg::*;
#(
  parameter int unsigned NUM_ENT = 16,
  parameter int unsigned SLOT_W  = 12,
  localparam int unsigned IDX_W  = $clog2(NUM_ENT + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic                            sel_i,
  input  logic [CFG_W-1:0]                wdata_i,
  output logic [NUM_ENT-1:0][SLOT_W-1:0]  loc_o,
  output ent_cfg_t [NUM_ENT-1:0]          cfg_o,
  output logic [AP_W-1:0]                 fix_ap_o,
  output logic [DOM_W-1:0]                fix_dom_o,
  output logic                            fix_b_o
);
  ent_cfg_t wcfg;
  assign wcfg = ent_cfg_t'(wdata_i);

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_ent
    logic hit_w;
    assign hit_w = we_i && (idx_i == IDX_W'(n));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        loc_o[n] <= SLOT_W'(n);
        cfg_o[n] <= '{base: BASE_W'(n), default: '0};
      end else if (hit_w) begin
        if (sel_i) cfg_o[n] <= wcfg;
        else       loc_o[n] <= wdata_i[SLOT_W-1:0];
      end
    end
  end

  // fixed entry: only control word, only AP/domain/B kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fix_ap_o  <= '0;
      fix_dom_o <= '0;
      fix_b_o   <= 1'b0;
    end else if (we_i && sel_i && idx_i == IDX_W'(NUM_ENT)) begin
      fix_ap_o  <= wcfg.ap;
      fix_dom_o <= wcfg.dom;
      fix_b_o   <= wcfg.b;
    end
  end
endmodule

// File: rtl/l1pt_ent_match.sv
module l1pt_ent_match
  import hw_l1pt_pkg::*;
#(
  parameter int unsigned SLOT_W = 12
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] loc_i,
  input  ent_cfg_t          cfg_i,
  output logic              hit_o,
  output logic [31:0]       desc_o
);
  logic [SLOT_W:0]     off;
  logic [SLOT_W-1:0]   run_idx;
  logic [BASE_W-1:0]   sec_base;

  // extra bit catches slot < loc (no wrap)
  assign off      = {1'b0, slot_i} - {1'b0, loc_i};
  assign run_idx  = off[SLOT_W-1:0];
  assign hit_o    = !cfg_i.dis && !off[SLOT_W] && ((run_idx >> cfg_i.span) == '0);
  assign sec_base = cfg_i.base + BASE_W'(run_idx);
  assign desc_o   = mk_desc(sec_base, cfg_i.ap, cfg_i.dom, cfg_i.c, cfg_i.b);
endmodule

// File: rtl/l1pt_pick.sv
module l1pt_pick #(
  parameter int unsigned NUM_ENT = 16
) (
  input  logic [NUM_ENT-1:0]       hit_i,
  input  logic [NUM_ENT-1:0][31:0] desc_i,
  output logic                     any_o,
  output logic [31:0]              desc_o
);
  // scan high to low so the lowest index lands last
  always_comb begin
    desc_o = '0;
    for (int n = NUM_ENT - 1; n >= 0; n--) begin
      if (hit_i[n]) desc_o = desc_i[n];
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/hw_l1pt.sv
module hw_l1pt
  import hw_l1pt_pkg::*;
#(
  parameter int unsigned NUM_ENT    = 16,
  parameter int unsigned SLOT_W     = 12,
  parameter logic [31:0] WIN_BASE   = 32'h800C_0000,
  parameter int unsigned FIXED_SLOT = 2048,
  localparam int unsigned IDX_W     = $clog2(NUM_ENT + 1),
  localparam int unsigned WIN_LSB   = SLOT_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [31:0]      rd_addr_i,
  output logic             rd_valid_o,
  output logic [31:0]      rd_data_o,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i
);
  logic [NUM_ENT-1:0][SLOT_W-1:0] loc;
  ent_cfg_t [NUM_ENT-1:0]         cfg;
  logic [AP_W-1:0]                fix_ap;
  logic [DOM_W-1:0]               fix_dom;
  logic                           fix_b;

  l1pt_regs #(.NUM_ENT(NUM_ENT), .SLOT_W(SLOT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .loc_o(loc), .cfg_o(cfg),
    .fix_ap_o(fix_ap), .fix_dom_o(fix_dom), .fix_b_o(fix_b)
  );

  logic              in_win;
  logic [SLOT_W-1:0] slot;
  assign in_win = (rd_addr_i[31:WIN_LSB] == WIN_BASE[31:WIN_LSB]) && (rd_addr_i[1:0] == 2'b00);
  assign slot   = rd_addr_i[WIN_LSB-1:2];

  logic [NUM_ENT-1:0]       hit;
  logic [NUM_ENT-1:0][31:0] ent_desc;
  for (genvar n = 0; n < NUM_ENT; n++) begin : g_match
    l1pt_ent_match #(.SLOT_W(SLOT_W)) u_match (
      .slot_i(slot), .loc_i(loc[n]), .cfg_i(cfg[n]),
      .hit_o(hit[n]), .desc_o(ent_desc[n])
    );
  end

  logic        any_hit;
  logic [31:0] map_desc;
  l1pt_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .hit_i(hit), .desc_i(ent_desc), .any_o(any_hit), .desc_o(map_desc)
  );

  logic [31:0] fix_desc;
  logic [31:0] nxt_data;
  assign fix_desc = mk_desc(BASE_W'(FIXED_SLOT), fix_ap, fix_dom, 1'b0, fix_b);

  always_comb begin
    nxt_data = '0;
    if (rd_en_i && in_win) begin
      if (slot == SLOT_W'(FIXED_SLOT)) nxt_data = fix_desc;
      else if (any_hit)                nxt_data = map_desc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      rd_data_o  <= nxt_data;
    end
  end
endmodule

// File: rtl/hw_l1pt_chk.sv
module hw_l1pt_chk #(
  parameter logic [31:0] WIN_BASE = 32'h800C_0000,
  parameter int unsigned SLOT_W   = 12,
  parameter int unsigned FIXED_SLOT = 2048,
  localparam int unsigned WIN_LSB = SLOT_W + 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_en_i,
  input logic [31:0] rd_addr_i,
  input logic        rd_valid_o,
  input logic [31:0] rd_data_o
);
  logic in_win, is_fix;
  assign in_win = (rd_addr_i[31:WIN_LSB] == WIN_BASE[31:WIN_LSB]) && (rd_addr_i[1:0] == 2'b00);
  assign is_fix = in_win && (rd_addr_i[WIN_LSB-1:2] == SLOT_W'(FIXED_SLOT));

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_valid_o && rd_data_o == 32'h0));
  a_r1_outside_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !in_win) |=> rd_data_o == 32'h0);
  a_r2_fixed_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && is_fix) |=> (rd_data_o[31:20] == 12'h800 && rd_data_o[3] == 1'b0
                             && rd_data_o[1:0] == 2'b10));
  a_r10_format: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_data_o == 32'h0 ||
                    (rd_data_o[1:0] == 2'b10 && rd_data_o[19:12] == 8'h0
                     && rd_data_o[9] == 1'b0 && rd_data_o[4] == 1'b0)));
endmodule

bind hw_l1pt hw_l1pt_chk #(.WIN_BASE(WIN_BASE), .SLOT_W(SLOT_W), .FIXED_SLOT(FIXED_SLOT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
);

// File: tb/hw_l1pt_tb.sv
module hw_l1pt_tb;
  localparam logic [31:0] WIN = 32'h800C_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_addr_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_idx_i = '0;
  logic        cfg_sel_i = 1'b0;
  logic [23:0] cfg_wdata_i = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  hw_l1pt u_dut (.*);

  function automatic logic [31:0] dsc(logic [11:0] base, logic [1:0] ap, logic [3:0] dom,
                                      logic c, logic b);
    return (32'(base) << 20) | (32'(ap) << 10) | (32'(dom) << 5) | (32'(c) << 3)
         | (32'(b) << 2) | 32'h2;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(int idx, logic sel, logic [23:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 5'(idx); cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_addr(logic [31:0] a, string req, logic [31:0] exp);
    logic [31:0] d;
    logic v;
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o; v = rd_valid_o;
    chk({req, " valid"}, 32'(v), 32'h1);
    chk(req, d, exp);
  endtask

  task automatic rd_slot(int k, string req, logic [31:0] exp);
    rd_addr(WIN + 32'(k) * 4, req, exp);
  endtask

  task automatic t_reset;
    chk("R9 idle valid", 32'(rd_valid_o), 32'h0);
    chk("R9 idle data", rd_data_o, 32'h0);
    rd_slot(3, "R3 slot3", dsc(12'h003, 0, 0, 0, 0));
    rd_slot(15, "R3 slot15", dsc(12'h00F, 0, 0, 0, 0));
    rd_slot(16, "R8 slot16", 32'h0);
    rd_slot(2048, "R3 R2 fixed reset", 32'h8000_0002);
    @(negedge clk_i);
    chk("R9 after read valid", 32'(rd_valid_o), 32'h0);
  endtask

  task automatic t_window;
    rd_addr(WIN - 4, "R1 below window", 32'h0);
    rd_addr(WIN + 32'h4000, "R1 above window", 32'h0);
    rd_addr(WIN + 32'hC + 1, "R1 misaligned", 32'h0);
    rd_slot(4095, "R8 top slot", 32'h0);
  endtask

  task automatic t_span;
    wr(0, 1'b0, 24'h000100);
    wr(0, 1'b1, 24'h2005F3);
    rd_slot(32'h100, "R4 R10 span first", 32'h2000_0CAE);
    rd_slot(32'h107, "R5 span last", 32'h2070_0CAE);
    rd_slot(32'h108, "R4 span past end", 32'h0);
    rd_slot(32'h0FF, "R4 span before", 32'h0);
  endtask

  task automatic t_dis_prio;
    wr(0, 1'b1, 24'h2005FB);
    rd_slot(32'h100, "R6 disabled", 32'h0);
    wr(5, 1'b0, 24'h000100);
    wr(5, 1'b1, 24'h333000);
    rd_slot(32'h100, "R6 R7 only entry5", dsc(12'h333, 0, 0, 0, 0));
    wr(0, 1'b1, 24'h2005F3);
    rd_slot(32'h100, "R7 lowest wins", 32'h2000_0CAE);
  endtask

  task automatic t_fixed;
    wr(2, 1'b0, 24'h0007FC);
    wr(2, 1'b1, 24'h010003);
    rd_slot(32'h801, "R5 straddle", dsc(12'h015, 0, 0, 0, 0));
    rd_slot(32'h7FC, "R4 straddle low", dsc(12'h010, 0, 0, 0, 0));
    rd_slot(2048, "R2 fixed beats entry", 32'h8000_0002);
    wr(16, 1'b1, 24'hFFFAB7);
    rd_slot(2048, "R2 R12 fixed attrs", 32'h8000_0946);
  endtask

  task automatic t_ignore;
    wr(20, 1'b1, 24'h00000B);
    wr(31, 1'b0, 24'h000200);
    rd_slot(3, "R12 idx 20/31 ignored", dsc(12'h003, 0, 0, 0, 0));
    wr(16, 1'b0, 24'h000004);
    rd_slot(4, "R12 fixed loc ignored", dsc(12'h004, 0, 0, 0, 0));
    rd_slot(2048, "R12 fixed unchanged", 32'h8000_0946);
  endtask

  task automatic t_wrap;
    wr(1, 1'b0, 24'h000FF0);
    wr(1, 1'b1, 24'hFFE007);
    rd_slot(32'hFF0, "R11 span7 first", dsc(12'hFFE, 0, 0, 0, 0));
    rd_slot(32'hFF2, "R5 base wrap", dsc(12'h000, 0, 0, 0, 0));
    rd_slot(32'hFFF, "R5 R4 last slot", dsc(12'h00D, 0, 0, 0, 0));
    rd_slot(0, "R4 no wrap to slot0", 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog got %h exp %h", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_window();
    t_span();
    t_dis_prio();
    t_fixed();
    t_ignore();
    t_wrap();
    repeat (2) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule